// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block turns time-base events into two PWM output levels. An external time base supplies a counter value, strobes that mark the counter reaching zero and reaching its period, and a clock enable that marks each prescaled tick. Inside, two compare registers are matched against the counter. Each output has its own action register. That register states what the output does when a zero, period, compare-A-up or compare-B-up event occurs: nothing, drive low, drive high, or toggle. When several events fall on the same tick, one winner is chosen by a fixed priority.

A continuous force can override either output with a fixed level. Software writes the force request into a shadow register. The shadow is copied to the active force at a selectable point: counter zero, period, either of them, or the next tick. While a force is active, the event logic keeps running underneath. When the force is released, the output shows whatever level the events have produced in the meantime.

All configuration goes through a simple write port with a register select. Output A is normally set up against compare register A and output B against compare register B.

Top module: `pwm_action_qual`

## Requirements
- R1: During reset and after it, both outputs are low, all configuration registers are zero, and no action or force is in effect.
- R2: An action code of 0 leaves the output level unchanged, 1 drives it low, 2 drives it high and 3 inverts it. The code takes effect at the tick on which its event occurs.
- R3: In each output's action register, bits 1:0 hold the zero-event code, bits 3:2 the period-event code, bits 5:4 the compare-A-up code and bits 9:8 the compare-B-up code. Compare A fires when the counter equals compare register A, and compare B fires when it equals compare register B.
- R4: When several events with non-zero codes occur on one tick, only the highest one acts. The order from highest to lowest is compare B, compare A, period, zero. An event whose code is 0 does not block a lower event.
- R5: When the clock enable is low, counter value, event strobes and compare matches have no effect on either output.
- R6: Force-control bits 1:0 select the force for output A and bits 3:2 the force for output B. Code 1 holds the output low and code 2 holds it high. Codes 0 and 3 leave the output under event control.
- R7: Force-control bits 7:6 choose when the force shadow becomes active. The choices are 0 for a tick with a zero event, 1 for a tick with a period event, 2 for a tick with either event, and 3 for the next tick. Until that point the previously active force stays in effect.
- R8: While a force is active, events still update the output's underlying level. On release, the output shows that level from the same tick.
- R9: Write select 0 loads compare A, 1 loads compare B, 2 loads the action register of A, 3 loads the action register of B, and 4 loads force control. Writes to any other select change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Prescaled tick: events are evaluated only when high |
| ctr | input | CW (16) | Time-base counter value |
| zero_evt | input | 1 | Counter-at-zero strobe |
| prd_evt | input | 1 | Counter-at-period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | AW (3) | Register select for the write |
| wr_data | input | DW (16) | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Two kinds of work can fall on the same tick. The first is several time-base events at once: the bench sets both compare registers to one counter value and asserts the zero strobe on that tick. It then judges the winner from the level that follows, both for the case where compare B carries a code and for the case where it carries none. The second is a force reload together with an event-driven change. The bench forces a level, drives events that move the hidden level the other way, and then releases the force. The output must show the level the events produced while it was overridden, not the level from before the force.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

  // Number of PWM outputs handled by the block.
  localparam int NCH = 2;

  // Width of the used part of an action register.
  localparam int ACT_W = 10;

  // Field positions inside an action register.
  localparam int ZRO_LSB = 0;
  localparam int PRD_LSB = 2;
  localparam int CAU_LSB = 4;
  localparam int CBU_LSB = 8;

  // Force-control layout.
  localparam int FRC_W   = 8;
  localparam int RLD_LSB = 6;

  // Register selects.
  localparam int SEL_CMPA = 0;
  localparam int SEL_CMPB = 1;
  localparam int SEL_ACTA = 2;
  localparam int SEL_ACTB = 3;
  localparam int SEL_FRC  = 4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'd0,
    RLD_PRD  = 2'd1,
    RLD_BOTH = 2'd2,
    RLD_NOW  = 2'd3
  } rld_e;

  typedef struct packed {
    logic zero;
    logic prd;
    logic cau;
    logic cbu;
  } evt_t;

  function automatic logic apply_act(act_e code, logic cur);
    case (code)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
  import pwmaq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_sel,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            cmp_a_q,
  output logic [DW-1:0]            cmp_b_q,
  output logic [NCH-1:0][DW-1:0]   act_q,
  output logic [FRC_W-1:0]         frc_q
);

  localparam logic [AW-1:0] A_CMPA = AW'(SEL_CMPA);
  localparam logic [AW-1:0] A_CMPB = AW'(SEL_CMPB);
  localparam logic [AW-1:0] A_ACTA = AW'(SEL_ACTA);
  localparam logic [AW-1:0] A_ACTB = AW'(SEL_ACTB);
  localparam logic [AW-1:0] A_FRC  = AW'(SEL_FRC);

  logic [DW-1:0]          cmp_a_d, cmp_b_d;
  logic [NCH-1:0][DW-1:0] act_d;
  logic [FRC_W-1:0]       frc_d;

  always_comb begin
    cmp_a_d = cmp_a_q;
    cmp_b_d = cmp_b_q;
    act_d   = act_q;
    frc_d   = frc_q;
    if (wr_en) begin
      case (wr_sel)
        A_CMPA:  cmp_a_d  = wr_data;
        A_CMPB:  cmp_b_d  = wr_data;
        A_ACTA:  act_d[0] = wr_data;
        A_ACTB:  act_d[1] = wr_data;
        A_FRC:   frc_d    = wr_data[FRC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      act_q   <= '0;
      frc_q   <= '0;
    end else begin
      cmp_a_q <= cmp_a_d;
      cmp_b_q <= cmp_b_d;
      act_q   <= act_d;
      frc_q   <= frc_d;
    end
  end

endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
  import pwmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  evt_t             ev,
  input  logic [ACT_W-1:0] act,
  output logic             lvl_q
);

  act_e win;
  logic lvl_d;

  // Later assignments override earlier ones: zero < period < cmpA < cmpB.
  always_comb begin
    win = ACT_NONE;
    if (ev.zero && act[ZRO_LSB+:2] != 2'd0) win = act_e'(act[ZRO_LSB+:2]);
    if (ev.prd  && act[PRD_LSB+:2] != 2'd0) win = act_e'(act[PRD_LSB+:2]);
    if (ev.cau  && act[CAU_LSB+:2] != 2'd0) win = act_e'(act[CAU_LSB+:2]);
    if (ev.cbu  && act[CBU_LSB+:2] != 2'd0) win = act_e'(act[CBU_LSB+:2]);
  end

  always_comb begin
    lvl_d = lvl_q;
    if (tick_en) lvl_d = apply_act(win, lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

endmodule

// File: rtl/pwmaq_force.sv
module pwmaq_force
  import pwmaq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               zero_evt,
  input  logic               prd_evt,
  input  logic [2*NCH-1:0]   shadow,
  input  logic [1:0]         rld,
  output logic [2*NCH-1:0]   active_q
);

  logic             load;
  logic [2*NCH-1:0] active_d;

  always_comb begin
    case (rld_e'(rld))
      RLD_ZERO: load = zero_evt;
      RLD_PRD:  load = prd_evt;
      RLD_BOTH: load = zero_evt | prd_evt;
      default:  load = 1'b1;
    endcase
    load     = load & tick_en;
    active_d = load ? shadow : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwmaq_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] ctr,
  input  logic          zero_evt,
  input  logic          prd_evt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);

  localparam int SYNC_N = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int = rst_sync_q[SYNC_N-1];

  logic [DW-1:0]          cmp_a, cmp_b;
  logic [NCH-1:0][DW-1:0] act_q;
  logic [FRC_W-1:0]       frc_ctl;
  logic [2*NCH-1:0]       frc_act;
  logic [NCH-1:0]         ev_lvl;
  logic [NCH-1:0]         pwm_v;
  evt_t                   ev;

  pwmaq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cmp_a_q (cmp_a),
    .cmp_b_q (cmp_b),
    .act_q   (act_q),
    .frc_q   (frc_ctl)
  );

  always_comb begin
    ev.zero = zero_evt;
    ev.prd  = prd_evt;
    ev.cau  = (DW'(ctr) == cmp_a);
    ev.cbu  = (DW'(ctr) == cmp_b);
  end

  pwmaq_force u_force (
    .clk      (clk),
    .rst_n    (rst_int),
    .tick_en  (tick_en),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .shadow   (frc_ctl[2*NCH-1:0]),
    .rld      (frc_ctl[RLD_LSB+:2]),
    .active_q (frc_act)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmaq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_int),
      .tick_en (tick_en),
      .ev      (ev),
      .act     (act_q[g][ACT_W-1:0]),
      .lvl_q   (ev_lvl[g])
    );

    always_comb begin
      case (frc_act[2*g+:2])
        2'd1:    pwm_v[g] = 1'b0;
        2'd2:    pwm_v[g] = 1'b1;
        default: pwm_v[g] = ev_lvl[g];
      endcase
    end
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

endmodule

// File: rtl/pwmaq_chk.sv
module pwmaq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        zero_evt,
  input logic        prd_evt,
  input logic [15:0] ctr,
  input logic [15:0] cmp_a,
  input logic [15:0] cmp_b,
  input logic [9:0]  act_a,
  input logic [3:0]  frc_shadow,
  input logic [3:0]  frc_active,
  input logic [1:0]  rld,
  input logic        pwm_a,
  input logic        pwm_b
);

  logic a_free;
  assign a_free = (frc_active[1:0] == 2'd0 || frc_active[1:0] == 2'd3) &&
                  (frc_shadow[1:0] == 2'd0 || frc_shadow[1:0] == 2'd3);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_low_chk: assert (!pwm_a && !pwm_b);
    end
  end

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(pwm_a) && $stable(pwm_b)));

  // R7
  force_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && rld == 2'd3 && frc_shadow[1:0] == 2'd2) |=> pwm_a);

  // R6
  force_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && rld == 2'd3 && frc_shadow[3:2] == 2'd1) |=> !pwm_b);

  // R2
  zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && zero_evt && !prd_evt && ctr != cmp_a && ctr != cmp_b &&
     act_a[1:0] == 2'd2 && a_free) |=> pwm_a);

  // R4
  cbu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctr == cmp_a && ctr == cmp_b && act_a[9:8] == 2'd1 &&
     act_a[5:4] == 2'd2 && a_free) |=> !pwm_a);

endmodule

bind pwm_action_qual pwmaq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int),
  .tick_en    (tick_en),
  .zero_evt   (zero_evt),
  .prd_evt    (prd_evt),
  .ctr        (ctr),
  .cmp_a      (cmp_a),
  .cmp_b      (cmp_b),
  .act_a      (act_q[0][9:0]),
  .frc_shadow (frc_ctl[3:0]),
  .frc_active (frc_act),
  .rld        (frc_ctl[7:6]),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b)
);

// File: tb/tb_pwm_action_qual.sv
module tb_pwm_action_qual;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [15:0] ctr;
  logic        zero_evt;
  logic        prd_evt;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic        pwm_a;
  logic        pwm_b;

  int n_chk;
  int n_bad;
  bit done;

  pwm_action_qual dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ctr      (ctr),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [15:0] c, input logic z, input logic p);
    @(negedge clk);
    ctr = c; zero_evt = z; prd_evt = p; tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; zero_evt = 1'b0; prd_evt = 1'b0;
  endtask

  task automatic t_reset();
    check(pwm_a, 1'b0, "R1 pwm_a after reset");
    check(pwm_b, 1'b0, "R1 pwm_b after reset");
    tick(16'd0, 1'b1, 1'b0);
    check(pwm_a, 1'b0, "R1 no action configured");
  endtask

  task automatic t_normal_a();
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h001A);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R2 zero drives high");
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b1, "R3 no event holds");
    tick(16'd5, 1'b0, 1'b0); check(pwm_a, 1'b0, "R3 cmpA-up drives low");
    tick(16'd9, 1'b0, 1'b1); check(pwm_a, 1'b1, "R3 period drives high");
  endtask

  task automatic t_inverted_b();
    wr(3'd1, 16'd7);
    wr(3'd3, 16'h0205);
    tick(16'd0, 1'b1, 1'b0); check(pwm_b, 1'b0, "R3 B zero drives low");
    tick(16'd7, 1'b0, 1'b0); check(pwm_b, 1'b1, "R3 B cmpB-up drives high");
    tick(16'd9, 1'b0, 1'b1); check(pwm_b, 1'b0, "R3 B period drives low");
  endtask

  task automatic t_toggle();
    wr(3'd2, 16'h0003);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R2 toggle to low");
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R2 toggle to high");
    wr(3'd2, 16'h0000);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R2 code 0 no action");
  endtask

  task automatic t_priority();
    wr(3'd2, 16'h0121);
    wr(3'd0, 16'd4);
    wr(3'd1, 16'd4);
    tick(16'd4, 1'b1, 1'b0);
    check(pwm_a, 1'b0, "R4 cmpB beats cmpA and zero");
    check(pwm_b, 1'b1, "R4 B cmpB beats zero");
    wr(3'd1, 16'd6);
    tick(16'd4, 1'b1, 1'b0); check(pwm_a, 1'b1, "R4 cmpA beats zero");
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R4 lone zero acts");
    wr(3'd2, 16'h0021);
    wr(3'd1, 16'd4);
    tick(16'd4, 1'b1, 1'b0); check(pwm_a, 1'b1, "R4 code 0 on cmpB does not block cmpA");
  endtask

  task automatic t_gate();
    wr(3'd2, 16'h0003);
    @(negedge clk);
    ctr = 16'd0; zero_evt = 1'b1; tick_en = 1'b0;
    @(negedge clk);
    zero_evt = 1'b0;
    check(pwm_a, 1'b1, "R5 zero ignored without tick");
    @(negedge clk);
    ctr = 16'd4;
    @(negedge clk);
    check(pwm_a, 1'b1, "R5 compare ignored without tick");
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R5 tick applies event");
  endtask

  task automatic t_force_modes();
    wr(3'd2, 16'h0001);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R2 zero drives low");
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0002);
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b0, "R7 zero mode waits");
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R7 zero mode loads at zero");
    wr(3'd4, 16'h0041);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R7 period mode ignores zero");
    tick(16'd9, 1'b0, 1'b1); check(pwm_a, 1'b0, "R7 period mode loads at period");
    wr(3'd4, 16'h0082);
    tick(16'd9, 1'b0, 1'b1); check(pwm_a, 1'b1, "R7 both mode loads at period");
    wr(3'd4, 16'h0081);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R7 both mode loads at zero");
    wr(3'd4, 16'h00C2);
    check(pwm_a, 1'b0, "R7 immediate waits for tick");
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b1, "R7 immediate at next tick");
  endtask

  task automatic t_release();
    wr(3'd2, 16'h0001);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b1, "R8 force holds over event");
    wr(3'd4, 16'h00C3);
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b0, "R8 release shows event level");
    wr(3'd2, 16'h0002);
    wr(3'd4, 16'h00C1);
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b0, "R6 force low");
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R6 force low over high event");
    wr(3'd4, 16'h00C0);
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b1, "R8 release resumes high");
  endtask

  task automatic t_force_b();
    wr(3'd2, 16'h0001);
    tick(16'd0, 1'b1, 1'b0);
    wr(3'd4, 16'h00C8);
    tick(16'd3, 1'b0, 1'b0);
    check(pwm_b, 1'b1, "R6 B force high");
    check(pwm_a, 1'b0, "R6 A unaffected by B force");
    wr(3'd4, 16'h00C4);
    tick(16'd3, 1'b0, 1'b0); check(pwm_b, 1'b0, "R6 B force low");
    wr(3'd4, 16'h00C0);
    tick(16'd3, 1'b0, 1'b0);
  endtask

  task automatic t_bad_sel();
    wr(3'd2, 16'h0001);
    tick(16'd0, 1'b1, 1'b0); check(pwm_a, 1'b0, "R9 setup low");
    wr(3'd2, 16'h0020);
    wr(3'd0, 16'd10);
    wr(3'd5, 16'd3);
    wr(3'd6, 16'd3);
    wr(3'd7, 16'd3);
    tick(16'd3, 1'b0, 1'b0); check(pwm_a, 1'b0, "R9 unused selects ignored");
    tick(16'd10, 1'b0, 1'b0); check(pwm_a, 1'b1, "R9 cmpA kept");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; ctr = '0; zero_evt = 1'b0; prd_evt = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal_a();
    t_inverted_b();
    t_toggle();
    t_priority();
    t_gate();
    t_force_modes();
    t_release();
    t_force_b();
    t_bad_sel();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule